// File: doc/BRIEF.md
# Peripheral DMA Channel with Buffer Reload

The block is one DMA channel that moves data between a peripheral and memory, one unit per request. Software sets it up through a small register window: a peripheral index, a memory address, a unit count and a mode. It then enables the channel. Each time the selected peripheral raises its request, the channel makes exactly one memory access. In the peripheral-to-memory direction this is a write of the peripheral's data. In the memory-to-peripheral direction it is a read whose data is handed to the peripheral. The peripheral's acknowledge is pulsed once the access completes. After each unit the address steps forward by the unit size and the count drops by one.

A second buffer can be queued in the reload address and reload count registers. When the running count reaches zero, the queued buffer takes over in the same cycle and the reload count is emptied, so software can queue the next buffer. In ring mode the reload registers are kept, and the same buffer repeats without end.

Three level-sensitive conditions (reload empty, transfer done, bus error) are combined with a software mask to drive one interrupt line. There is no write-to-clear: a condition goes away only when its cause is removed.

Top module: `pdma_channel`

## Requirements
- R1: After reset, every register reads zero except the interrupt status, which reads 3 (both counts zero). The channel is disabled, `irq` is low, `mem_req` is low and `per_ack` is zero.
- R2: Writing control (offset 0x14) with bit 0 set enables the channel and clears the error condition. Bit 1 set disables it, and disable wins if both bits are set. Status (offset 0x1C) bit 0 reads back the enable.
- R3: While the channel is enabled and the count is non-zero, a request on the peripheral chosen by the select register (offset 0x04, low bits) starts exactly one memory access. When that access completes, `per_ack` of that peripheral pulses for one cycle, and the peripheral drops its request on seeing it. Requests on other peripherals are ignored.
- R4: Mode bit 4 chooses the direction. 0 means peripheral to memory: `per_rdata`, sampled when the request is taken, is written to memory. 1 means memory to peripheral: the read data appears on `per_wdata` during the acknowledge cycle.
- R5: Mode bits [1:0] give the unit size: 0 is a byte, 1 a halfword and 2 a word (3 is treated as a word). `mem_size` carries this field. Each completed unit adds 1, 2 or 4 to the address and subtracts one from the count.
- R6: With the channel disabled or the count at zero, no memory access starts.
- R7: When a unit brings the count to zero and the reload count (offset 0x10) is non-zero, the address takes the reload address (offset 0x0C) and the count takes the reload count, and the reload count becomes zero, all in that same cycle.
- R8: With mode bit 3 (ring) set, the same handover happens but the reload registers keep their values, so the buffer repeats.
- R9: Interrupt status (offset 0x2C) has three bits: bit 0 is reload count zero, bit 1 is count zero, bit 2 is bus error. Writing the status offset has no effect. Bits 0 and 1 drop once the matching count register is written non-zero.
- R10: Writing 1s to offset 0x20 sets mask bits, writing 1s to offset 0x24 clears them, and offset 0x28 reads the mask. `irq` is high exactly when a masked-in status bit is set.
- R11: An error response completing a memory access sets status bit 2 and disables the channel. The address and count are left unchanged and no acknowledge is given.
- R12: The registers are word-aligned in a 64-byte window: address 0x00, select 0x04, count 0x08, reload address 0x0C, reload count 0x10, control 0x14, mode 0x18, status 0x1C, mask set 0x20, mask clear 0x24, mask 0x28, interrupt status 0x2C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 6 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational on cfg_addr) |
| per_req | input | N_PER | Per-peripheral unit request |
| per_rdata | input | DATA_W | Data from the selected peripheral |
| per_ack | output | N_PER | Per-peripheral one-cycle acknowledge |
| per_wdata | output | DATA_W | Data to the selected peripheral |
| mem_req | output | 1 | Memory access pending |
| mem_we | output | 1 | 1 = memory write, 0 = read |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_size | output | 2 | Unit size code |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid with mem_done |
| mem_done | input | 1 | Memory access complete |
| mem_err | input | 1 | Error response, qualified by mem_done |
| irq | output | 1 | Level interrupt |

## Verification
Random peripheral-to-memory buffers are run with every unit size, random lengths, aligned bases and random peripheral indices. They show whether the byte lanes, address step and count step agree for each size, and whether the select decode picks the right port. Directed cases cover the rest:
- a memory-to-peripheral read, to tell the two directions apart;
- a one-shot reload against a ring reload, which differ only in whether the reload count survives;
- requests while disabled, at count zero and on an unselected port;
- a bus error mid-buffer, to show that the error leaves the address and count untouched.

Interrupt cases toggle the mask and rewrite the counts to show level behaviour with no write-to-clear.

// File: rtl/pdma_pkg.sv
package pdma_pkg;

    // Word index (offset bits [5:2]) of each register
    localparam logic [3:0] IDX_ADDR   = 4'd0;
    localparam logic [3:0] IDX_PSEL   = 4'd1;
    localparam logic [3:0] IDX_CNT    = 4'd2;
    localparam logic [3:0] IDX_RADDR  = 4'd3;
    localparam logic [3:0] IDX_RCNT   = 4'd4;
    localparam logic [3:0] IDX_CTRL   = 4'd5;
    localparam logic [3:0] IDX_MODE   = 4'd6;
    localparam logic [3:0] IDX_STAT   = 4'd7;
    localparam logic [3:0] IDX_MSET   = 4'd8;
    localparam logic [3:0] IDX_MCLR   = 4'd9;
    localparam logic [3:0] IDX_MASK   = 4'd10;
    localparam logic [3:0] IDX_ISTAT  = 4'd11;

    localparam int N_IRQ = 3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_ACK  = 2'd2
    } xfer_state_e;

endpackage

// File: rtl/pdma_req_sel.sv
module pdma_req_sel #(
    parameter int N_PER = 4,
    parameter int SEL_W = 2
) (
    input  logic [SEL_W-1:0] sel,
    input  logic [N_PER-1:0] per_req,
    input  logic             ack_pulse,
    output logic             req_hit,
    output logic [N_PER-1:0] per_ack
);

    logic [N_PER-1:0] hit_v;

    for (genvar i = 0; i < N_PER; i++) begin : g_port
        assign hit_v[i]   = per_req[i] && (sel == SEL_W'(i));
        assign per_ack[i] = ack_pulse && (sel == SEL_W'(i));
    end

    assign req_hit = |hit_v;

endmodule

// File: rtl/pdma_irq_ctl.sv
module pdma_irq_ctl #(
    parameter int N_IRQ = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_we,
    input  logic             clr_we,
    input  logic [N_IRQ-1:0] bits,
    input  logic [N_IRQ-1:0] status,
    output logic [N_IRQ-1:0] mask,
    output logic             irq
);

    logic [N_IRQ-1:0] mask_d, mask_q;

    always_comb begin
        mask_d = mask_q;
        if (set_we) mask_d = mask_d | bits;
        if (clr_we) mask_d = mask_d & ~bits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_d;
    end

    assign mask = mask_q;
    assign irq  = |(mask_q & status);

    // R10
    mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_we && !clr_we && bits[1]) |=> mask_q[1]);

    // R10
    mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && bits[0]) |=> !mask_q[0]);

endmodule

// File: rtl/pdma_channel.sv
module pdma_channel
    import pdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32,
    parameter int N_PER  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [5:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic [N_PER-1:0]  per_req,
    input  logic [DATA_W-1:0] per_rdata,
    output logic [N_PER-1:0]  per_ack,
    output logic [DATA_W-1:0] per_wdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_size,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_done,
    input  logic              mem_err,
    output logic              irq
);

    localparam int SEL_W = (N_PER > 1) ? $clog2(N_PER) : 1;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] raddr;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  rcnt;
        logic [SEL_W-1:0]  sel;
        logic [1:0]        size;
        logic              ring;
        logic              m2p;
        logic              en;
        logic              err;
        xfer_state_e       state;
        logic [DATA_W-1:0] buf_data;
    } chan_t;

    chan_t d, q;

    logic [3:0]        widx;
    logic              wr_hit;
    logic              req_hit;
    logic [ADDR_W-1:0] step;
    logic [N_IRQ-1:0]  istat;
    logic [N_IRQ-1:0]  imask;

    assign widx   = cfg_addr[5:2];
    assign wr_hit = cfg_we && (cfg_addr[1:0] == 2'b00);

    always_comb begin
        case (q.size)
            2'd0:    step = ADDR_W'(1);
            2'd1:    step = ADDR_W'(2);
            default: step = ADDR_W'(4);
        endcase
    end

    pdma_req_sel #(.N_PER(N_PER), .SEL_W(SEL_W)) u_req_sel (
        .sel       (q.sel),
        .per_req   (per_req),
        .ack_pulse (q.state == ST_ACK),
        .req_hit   (req_hit),
        .per_ack   (per_ack)
    );

    always_comb begin
        d = q;
        case (q.state)
            ST_IDLE: begin
                if (q.en && (q.cnt != '0) && req_hit) begin
                    d.state    = ST_BUSY;
                    d.buf_data = per_rdata;
                end
            end
            ST_BUSY: begin
                if (mem_done) begin
                    if (mem_err) begin
                        d.err   = 1'b1;
                        d.en    = 1'b0;
                        d.state = ST_IDLE;
                    end else begin
                        d.state = ST_ACK;
                        if (q.m2p) d.buf_data = mem_rdata;
                        d.addr = q.addr + step;
                        d.cnt  = q.cnt - CNT_W'(1);
                        if ((q.cnt == CNT_W'(1)) && (q.rcnt != '0)) begin
                            d.addr = q.raddr;
                            d.cnt  = q.rcnt;
                            if (!q.ring) d.rcnt = '0;
                        end
                    end
                end
            end
            default: d.state = ST_IDLE;
        endcase

        if (wr_hit) begin
            case (widx)
                IDX_ADDR:  d.addr  = cfg_wdata[ADDR_W-1:0];
                IDX_PSEL:  d.sel   = cfg_wdata[SEL_W-1:0];
                IDX_CNT:   d.cnt   = cfg_wdata[CNT_W-1:0];
                IDX_RADDR: d.raddr = cfg_wdata[ADDR_W-1:0];
                IDX_RCNT:  d.rcnt  = cfg_wdata[CNT_W-1:0];
                IDX_CTRL: begin
                    if (cfg_wdata[0]) begin
                        d.en  = 1'b1;
                        d.err = 1'b0;
                    end
                    if (cfg_wdata[1]) d.en = 1'b0;
                end
                IDX_MODE: begin
                    d.size = cfg_wdata[1:0];
                    d.ring = cfg_wdata[3];
                    d.m2p  = cfg_wdata[4];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign istat = {q.err, (q.cnt == '0), (q.rcnt == '0)};

    pdma_irq_ctl #(.N_IRQ(N_IRQ)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_we (wr_hit && (widx == IDX_MSET)),
        .clr_we (wr_hit && (widx == IDX_MCLR)),
        .bits   (cfg_wdata[N_IRQ-1:0]),
        .status (istat),
        .mask   (imask),
        .irq    (irq)
    );

    always_comb begin
        cfg_rdata = '0;
        case (widx)
            IDX_ADDR:  cfg_rdata = 32'(q.addr);
            IDX_PSEL:  cfg_rdata = 32'(q.sel);
            IDX_CNT:   cfg_rdata = 32'(q.cnt);
            IDX_RADDR: cfg_rdata = 32'(q.raddr);
            IDX_RCNT:  cfg_rdata = 32'(q.rcnt);
            IDX_MODE:  cfg_rdata = {27'd0, q.m2p, q.ring, 1'b0, q.size};
            IDX_STAT:  cfg_rdata = {31'd0, q.en};
            IDX_MASK:  cfg_rdata = 32'(imask);
            IDX_ISTAT: cfg_rdata = 32'(istat);
            default:   cfg_rdata = '0;
        endcase
    end

    assign mem_req   = (q.state == ST_BUSY);
    assign mem_we    = !q.m2p;
    assign mem_addr  = q.addr;
    assign mem_size  = q.size;
    assign mem_wdata = q.buf_data;
    assign per_wdata = q.buf_data;

    // R6
    idle_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_IDLE && (!q.en || q.cnt == '0)) |=> !mem_req);

    // R11
    err_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_done && mem_err && !cfg_we) |=> (!q.en && q.err && per_ack == '0));

    // R3
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_done && !cfg_we) |=> (mem_req && $stable(mem_addr)));

    // R5
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_done && !mem_err && !cfg_we && q.cnt > CNT_W'(1))
        |=> (q.cnt == $past(q.cnt) - CNT_W'(1)));

    // R3
    ack_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (per_ack != '0) |-> $past(mem_req && mem_done && !mem_err));

endmodule

// File: tb/pdma_channel_bench.sv
module pdma_channel_bench;

    localparam int CLK_PERIOD = 10;
    localparam int N_PER = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [N_PER-1:0] per_req = '0;
    logic [31:0] per_rdata = '0;
    logic [N_PER-1:0] per_ack;
    logic [31:0] per_wdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [1:0]  mem_size;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_done = 1'b0;
    logic        mem_err = 1'b0;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;
    int err_req = 0;
    int err_ack = 0;
    int lat = 0;
    logic [7:0] mem_b [256];

    always #(CLK_PERIOD/2) clk = ~clk;

    pdma_channel #(.N_PER(N_PER)) u_pdma_channel (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .per_req(per_req),
        .per_rdata(per_rdata), .per_ack(per_ack), .per_wdata(per_wdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_done(mem_done), .mem_err(mem_err), .irq(irq)
    );

    function automatic int unit_bytes(input logic [1:0] s);
        return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
    endfunction

    function automatic logic [7:0] rd_pattern(input logic [31:0] a);
        return 8'((a * 7) + 3);
    endfunction

    // Memory stand-in: random latency, optional injected error
    always @(negedge clk) begin
        if (mem_done) begin
            mem_done = 1'b0;
            mem_err  = 1'b0;
        end else if (mem_req) begin
            if (lat > 0) lat--;
            else begin
                if (err_req != err_ack) begin
                    err_ack = err_req;
                    mem_err = 1'b1;
                end else begin
                    mem_rdata = '0;
                    for (int i = 0; i < unit_bytes(mem_size); i++) begin
                        if (mem_we) mem_b[8'(mem_addr + 32'(i))] = mem_wdata[8*i +: 8];
                        else mem_rdata[8*i +: 8] = rd_pattern(mem_addr + 32'(i));
                    end
                end
                mem_done = 1'b1;
                lat = $urandom % 3;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] v);
        @(negedge clk);
        cfg_addr = a;
        #1 v = cfg_rdata;
    endtask

    task automatic push(input int k, input logic [31:0] data, input int tmo,
                        output bit ok, output logic [31:0] got);
        @(negedge clk);
        per_req[k] = 1'b1; per_rdata = data; ok = 0; got = '0;
        for (int i = 0; i < tmo; i++) begin
            @(negedge clk);
            if (per_ack != '0) begin
                ok = per_ack[k];
                got = per_wdata;
                break;
            end
        end
        per_req[k] = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        logic [31:0] v, got, data;
        bit ok;
        for (int i = 0; i < 256; i++) mem_b[i] = 8'h00;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(6'h00, v); chk("R1 addr", v, 0);
        rd(6'h08, v); chk("R1 count", v, 0);
        rd(6'h1C, v); chk("R1 enable", v, 0);
        rd(6'h28, v); chk("R1 mask", v, 0);
        rd(6'h2C, v); chk("R1 istat", v, 3);
        chk("R1 irq/req/ack", {irq, mem_req, per_ack}, 0);

        // R2 control
        wr(6'h14, 1); rd(6'h1C, v); chk("R2 enable", v, 1);
        wr(6'h14, 3); rd(6'h1C, v); chk("R2 disable wins", v, 0);
        wr(6'h14, 1); rd(6'h1C, v); chk("R2 re-enable", v, 1);

        // R3 R4 R5 R12: random peripheral-to-memory buffers
        for (int t = 0; t < 10; t++) begin
            logic [1:0] s;
            int n, k;
            logic [31:0] base;
            s = 2'($urandom % 3);
            n = 1 + $urandom % 5;
            k = $urandom % N_PER;
            base = ($urandom % 32) * 4;
            wr(6'h18, {30'd0, s});
            wr(6'h04, k);
            wr(6'h00, base);
            wr(6'h08, n);
            for (int u = 0; u < n; u++) begin
                data = $urandom;
                push(k, data, 40, ok, got);
                chk("R3 ack on selected port", ok, 1);
                for (int b = 0; b < unit_bytes(s); b++)
                    chk("R4 R5 memory byte",
                        mem_b[8'(base + 32'(u * unit_bytes(s) + b))], data[8*b +: 8]);
            end
            rd(6'h00, v); chk("R5 address step", v, base + 32'(n * unit_bytes(s)));
            rd(6'h08, v); chk("R5 count at end", v, 0);
            rd(6'h2C, v); chk("R9 count-zero bit", v[1], 1);
        end

        // R3 unselected port ignored
        wr(6'h18, 0); wr(6'h04, 1); wr(6'h00, 32'h90); wr(6'h08, 2);
        push(2, 32'hAA, 12, ok, got);
        chk("R3 unselected no ack", ok, 0);
        rd(6'h08, v); chk("R3 unselected count kept", v, 2);

        // R6 disabled, and count zero
        wr(6'h14, 2);
        push(1, 32'hBB, 12, ok, got);
        chk("R6 disabled no ack", ok, 0);
        rd(6'h08, v); chk("R6 disabled count kept", v, 2);
        wr(6'h08, 0); wr(6'h14, 1);
        push(1, 32'hCC, 12, ok, got);
        chk("R6 zero count no ack", ok, 0);
        chk("R6 memory untouched", mem_b[8'h90], 8'h00);

        // R4 memory to peripheral, word units
        wr(6'h18, 32'h12); wr(6'h00, 32'hA0); wr(6'h08, 2);
        for (int u = 0; u < 2; u++) begin
            logic [31:0] e;
            for (int b = 0; b < 4; b++) e[8*b +: 8] = rd_pattern(32'hA0 + 32'(u*4 + b));
            push(1, 32'h0, 40, ok, got);
            chk("R4 read ack", ok, 1);
            chk("R4 read data to peripheral", got, e);
        end
        rd(6'h00, v); chk("R4 R5 read address step", v, 32'hA8);

        // R7 one-shot reload
        wr(6'h18, 0); wr(6'h00, 32'h10); wr(6'h08, 2);
        wr(6'h0C, 32'h40); wr(6'h10, 3);
        rd(6'h2C, v); chk("R9 reload bit drops", v[0], 0);
        for (int u = 0; u < 2; u++) push(1, 32'h11 + u, 40, ok, got);
        rd(6'h00, v); chk("R7 address reloaded", v, 32'h40);
        rd(6'h08, v); chk("R7 count reloaded", v, 3);
        rd(6'h10, v); chk("R7 reload emptied", v, 0);
        rd(6'h2C, v); chk("R9 reload-empty set, count nonzero", v[1:0], 2'b01);
        for (int u = 0; u < 3; u++) push(1, 32'h21 + u, 40, ok, got);
        chk("R7 second buffer byte", mem_b[8'h42], 8'h23);
        rd(6'h08, v); chk("R7 second buffer done", v, 0);

        // R8 ring
        wr(6'h18, 32'h08); wr(6'h00, 32'h20); wr(6'h08, 2);
        wr(6'h0C, 32'h20); wr(6'h10, 2);
        push(1, 32'h31, 40, ok, got); push(1, 32'h32, 40, ok, got);
        rd(6'h00, v); chk("R8 ring address", v, 32'h20);
        rd(6'h08, v); chk("R8 ring count", v, 2);
        rd(6'h10, v); chk("R8 ring reload kept", v, 2);
        push(1, 32'h33, 40, ok, got);
        chk("R8 ring rewrite", mem_b[8'h20], 8'h33);

        // R9 R10 interrupts
        wr(6'h14, 2); wr(6'h08, 0);
        wr(6'h20, 2);
        rd(6'h28, v); chk("R10 mask set", v, 2);
        chk("R10 irq on count zero", irq, 1);
        wr(6'h2C, 32'hFFFF_FFFF);
        rd(6'h2C, v); chk("R9 status write ignored", v[1], 1);
        chk("R9 irq still high", irq, 1);
        wr(6'h08, 3);
        rd(6'h2C, v); chk("R9 count bit drops", v[1], 0);
        chk("R10 irq low", irq, 0);
        wr(6'h08, 0); wr(6'h24, 2);
        rd(6'h28, v); chk("R10 mask clear", v, 0);
        chk("R10 irq masked", irq, 0);

        // R11 bus error
        wr(6'h18, 0); wr(6'h00, 32'h60); wr(6'h08, 3); wr(6'h10, 0);
        wr(6'h20, 4); wr(6'h14, 1);
        err_req++;
        push(1, 32'h44, 20, ok, got);
        chk("R11 no ack on error", ok, 0);
        rd(6'h1C, v); chk("R11 disabled", v, 0);
        rd(6'h08, v); chk("R11 count kept", v, 3);
        rd(6'h00, v); chk("R11 address kept", v, 32'h60);
        rd(6'h2C, v); chk("R11 error bit", v[2], 1);
        chk("R11 irq", irq, 1);
        wr(6'h14, 1);
        rd(6'h2C, v); chk("R2 enable clears error", v[2], 0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule